// File: doc/BRIEF.md
# Serial Port Register Front End

This block gives a host processor the register view of a classic byte-wide PC serial port, while the actual character traffic goes to and from a simple console byte stream instead of a wire. The host reaches eight byte registers through a 3-bit offset with separate read and write strobes. Received console bytes are offered on a valid/ready input, and every transmitted byte leaves as a one-cycle strobe.

The block holds the interrupt enable, line control and modem control values. It builds line status and interrupt identification from its own state and drives a single interrupt line. The transmitter has no shifter. It always appears idle, and its "holding register empty" interrupt comes back a programmable number of clock cycles after each data write. The host sees the same pacing a real port would give, but no baud logic is needed.

Top module: `uart_regfront`

## Requirements
- R1: After reset, `irq` and `acc_err` are 0, and reads of offsets 1 (interrupt enable), 2 (identification), 3 (line control) and 4 (modem control) return 0.
- R2: While line control bit 7 is set, accesses to offsets 0 and 1 have no effect. Reads return 0, no byte is popped (`rx_ready` stays 0), no byte is sent (`tx_valid` stays 0), and the interrupt enable value is not changed.
- R3: With line control bit 7 clear, a read of offset 0 returns `rx_data` and pulses `rx_ready` in the same cycle when `rx_valid` is 1. It returns 0 without popping when `rx_valid` is 0. Either way, the receive cause and `irq` are 0 after that edge.
- R4: With line control bit 7 clear, a write to offset 0 drives the byte on `tx_data` with `tx_valid` high in that cycle. It also clears the transmit cause and `irq` at that edge.
- R5: A data write made while interrupt enable bit 1 (transmit) is set starts a countdown of DELAY cycles, and a later data write restarts it. `irq` rises and the transmit cause is set exactly DELAY clock edges after the write edge, provided the bit is still set. A write to the enable register that leaves `irq` low cancels the countdown.
- R6: A write to offset 1 stores the value. `irq` is then 1 if bit 1 is set, or if bit 0 (receive) is set while `rx_valid` is 1, and 0 otherwise. The transmit cause is dropped when bit 1 is clear, and the receive cause is dropped unless bit 0 and `rx_valid` are both 1.
- R7: A read of offset 2 returns 1 when any cause flag is set and 0 otherwise. Offset 3 reads back the last value written to it.
- R8: A read of offset 5 returns 0x60 (bit 6 transmitter empty, bit 5 holding register empty), with bit 0 set when `rx_valid` is 1.
- R9: Writing 0x1A (loopback bit 4 plus 0x0A) to offset 4 makes it read 0x9A, and any other value written there is ignored. Offsets 6 and 7 always read 0, and writes to offsets 2 and 7 are ignored.
- R10: A newly offered receive byte raises `irq` and sets the receive cause on the next edge when interrupt enable bit 0 is set. A byte still offered after a pop counts as new on the following cycle.
- R11: A write to offset 5 or 6 sets `acc_err`, which stays set until reset, and changes no other state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | AW | Register offset |
| host_rd | input | 1 | Read strobe |
| host_wr | input | 1 | Write strobe |
| host_wdata | input | DW | Write data |
| host_rdata | output | DW | Read data, valid in the strobe cycle |
| rx_data | input | DW | Console byte offered to the host |
| rx_valid | input | 1 | Console byte available |
| rx_ready | output | 1 | Console byte taken this cycle |
| tx_data | output | DW | Byte sent to the console |
| tx_valid | output | 1 | Send strobe |
| irq | output | 1 | Interrupt request |
| acc_err | output | 1 | Sticky flag for writes to read-only offsets |

## Verification
A stale cause flag shows up in the identification register on the very next read, while the interrupt line itself may look correct. For that reason, offset 2 is read after every event that should set or clear a cause. An off-by-one in the countdown moves the rise of `irq` by one cycle, so the line is sampled on the edge just before and the edge exactly at DELAY after each write, including after a restart. A divisor-access leak appears at once as a popped byte, a send strobe, or a changed enable value read back after bit 7 is cleared.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;
  localparam int OFF_DATA  = 0;
  localparam int OFF_IEN   = 1;
  localparam int OFF_IID   = 2;
  localparam int OFF_LCTL  = 3;
  localparam int OFF_MCTL  = 4;
  localparam int OFF_LSTAT = 5;
  localparam int OFF_MSTAT = 6;
  localparam int OFF_SCR   = 7;

  localparam int IEN_RX   = 0;
  localparam int IEN_TX   = 1;
  localparam int LCTL_DIV = 7;
  localparam int LS_DR    = 0;
  localparam int LS_THRE  = 5;
  localparam int LS_TEMT  = 6;

  localparam logic [7:0] MC_LOOP_CMD = 8'h1A;
  localparam logic [7:0] MC_LOOP_VAL = 8'h9A;

  function automatic logic [7:0] lstat_val(input logic avail);
    logic [7:0] v;
    v = '0;
    v[LS_TEMT] = 1'b1;
    v[LS_THRE] = 1'b1;
    v[LS_DR]   = avail;
    return v;
  endfunction

  function automatic logic [7:0] mctl_next(input logic [7:0] cur, input logic [7:0] wv);
    return (wv == MC_LOOP_CMD) ? MC_LOOP_VAL : cur;
  endfunction

  function automatic logic [7:0] iid_val(input logic txp, input logic rxp);
    return {7'd0, txp | rxp};
  endfunction
endpackage

// File: rtl/uart_rf_delay.sv
module uart_rf_delay #(
  parameter int DELAY = 300
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic cancel,
  output logic expire
);
  localparam int CW = $clog2(DELAY + 1);
  localparam logic [CW-1:0] CNT_TOP = CW'(DELAY);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt_q <= '0;
    else if (load)       cnt_q <= CNT_TOP;
    else if (cancel)     cnt_q <= '0;
    else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign expire = (cnt_q == CW'(1)) && !load && !cancel;

  p_cnt_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_TOP);
  p_expire_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !expire);
endmodule

// File: rtl/uart_rf_rdmux.sv
module uart_rf_rdmux
  import uart_rf_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic          rd,
  input  logic [AW-1:0] addr,
  input  logic          div_on,
  input  logic [DW-1:0] ier,
  input  logic [DW-1:0] lcr,
  input  logic [DW-1:0] mcr,
  input  logic          tx_pend,
  input  logic          rx_pend,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  output logic [DW-1:0] rdata
);
  always_comb begin
    rdata = '0;
    if (rd) begin
      case (int'(addr))
        OFF_DATA:  rdata = (!div_on && rx_valid) ? rx_data : '0;
        OFF_IEN:   rdata = div_on ? '0 : ier;
        OFF_IID:   rdata = DW'(iid_val(tx_pend, rx_pend));
        OFF_LCTL:  rdata = lcr;
        OFF_MCTL:  rdata = mcr;
        OFF_LSTAT: rdata = DW'(lstat_val(rx_valid));
        default:   rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/uart_regfront.sv
module uart_regfront
  import uart_rf_pkg::*;
#(
  parameter int DW    = 8,
  parameter int AW    = 3,
  parameter int DELAY = 300
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] host_addr,
  input  logic          host_rd,
  input  logic          host_wr,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_valid,
  output logic          rx_ready,
  output logic [DW-1:0] tx_data,
  output logic          tx_valid,
  output logic          irq,
  output logic          acc_err
);
  logic [DW-1:0] ier_q, lcr_q, mcr_q;
  logic tx_pend_q, rx_pend_q, irq_q, err_q, rx_seen_q;

  // decoded offsets
  logic sel_data, sel_ien, sel_lctl, sel_mctl, sel_ro;
  assign sel_data = host_addr == AW'(OFF_DATA);
  assign sel_ien  = host_addr == AW'(OFF_IEN);
  assign sel_lctl = host_addr == AW'(OFF_LCTL);
  assign sel_mctl = host_addr == AW'(OFF_MCTL);
  assign sel_ro   = (host_addr == AW'(OFF_LSTAT)) || (host_addr == AW'(OFF_MSTAT));

  // named internal events
  logic div_on, data_rd, rx_pop, tx_push, ien_wr, bad_wr, rx_arrive, ien_irq, tmr_load, tmr_cancel, tmr_expire;
  assign div_on     = lcr_q[LCTL_DIV];
  assign data_rd    = host_rd && sel_data && !div_on;
  assign rx_pop     = data_rd && rx_valid;
  assign tx_push    = host_wr && sel_data && !div_on;
  assign ien_wr     = host_wr && sel_ien && !div_on;
  assign bad_wr     = host_wr && sel_ro;
  assign rx_arrive  = rx_valid && !rx_seen_q;
  assign ien_irq    = host_wdata[IEN_TX] || (host_wdata[IEN_RX] && rx_valid);
  assign tmr_load   = tx_push && ier_q[IEN_TX];
  assign tmr_cancel = ien_wr && !ien_irq;

  uart_rf_delay #(.DELAY(DELAY)) u_delay (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .cancel(tmr_cancel), .expire(tmr_expire)
  );

  uart_rf_rdmux #(.DW(DW), .AW(AW)) u_rdmux (
    .rd(host_rd), .addr(host_addr), .div_on(div_on), .ier(ier_q), .lcr(lcr_q),
    .mcr(mcr_q), .tx_pend(tx_pend_q), .rx_pend(rx_pend_q), .rx_valid(rx_valid),
    .rx_data(rx_data), .rdata(host_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ier_q <= '0; lcr_q <= '0; mcr_q <= '0;
      tx_pend_q <= 1'b0; rx_pend_q <= 1'b0; irq_q <= 1'b0;
      err_q <= 1'b0; rx_seen_q <= 1'b0;
    end else begin
      rx_seen_q <= rx_valid && !rx_pop;
      // background events first; host actions below take precedence
      if (rx_arrive && ier_q[IEN_RX]) begin
        irq_q <= 1'b1; rx_pend_q <= 1'b1;
      end
      if (tmr_expire && ier_q[IEN_TX]) begin
        irq_q <= 1'b1; tx_pend_q <= 1'b1;
      end
      if (data_rd) begin
        irq_q <= 1'b0; rx_pend_q <= 1'b0;
      end
      if (tx_push) begin
        irq_q <= 1'b0; tx_pend_q <= 1'b0;
      end
      if (ien_wr) begin
        ier_q <= host_wdata;
        irq_q <= ien_irq;
        if (!host_wdata[IEN_TX]) tx_pend_q <= 1'b0;
        if (!(host_wdata[IEN_RX] && rx_valid)) rx_pend_q <= 1'b0;
      end
      if (host_wr && sel_lctl) lcr_q <= host_wdata;
      if (host_wr && sel_mctl) mcr_q <= DW'(mctl_next(8'(mcr_q), 8'(host_wdata)));
      if (bad_wr) err_q <= 1'b1;
    end
  end

  assign rx_ready = rx_pop;
  assign tx_valid = tx_push;
  assign tx_data  = host_wdata;
  assign irq      = irq_q;
  assign acc_err  = err_q;

  p_pop_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |=> !irq && !rx_pend_q);
  p_send_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |=> !irq && !tx_pend_q);
  p_div_keeps_ien_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && sel_ien && div_on) |=> $stable(ier_q));
  p_div_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (div_on && (sel_data || sel_ien)) |-> !rx_ready && !tx_valid);
  p_expire_raises_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_expire && ier_q[IEN_TX] && !host_rd && !host_wr) |=> irq && tx_pend_q);
  p_dr_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_addr == AW'(OFF_LSTAT)) |-> host_rdata[LS_DR] == rx_valid);
  p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |=> acc_err);
  p_cause_needs_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_pend_q) |-> irq);
endmodule

// File: tb/sim_uart_regfront.sv
module sim_uart_regfront;
  localparam int CLK_P = 10;
  localparam int DLY   = 300;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] host_addr = '0;
  logic       host_rd = 1'b0, host_wr = 1'b0;
  logic [7:0] host_wdata = '0, host_rdata, rx_data = '0, tx_data;
  logic       rx_valid = 1'b0, rx_ready, tx_valid, irq, acc_err;

  int checks = 0, errors = 0;
  bit done = 0;

  uart_regfront #(.DW(8), .AW(3), .DELAY(DLY)) u0 (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_rd(host_rd), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .tx_data(tx_data), .tx_valid(tx_valid), .irq(irq), .acc_err(acc_err)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic [7:0] rd_val;
  logic       rd_pop;
  logic       wr_tx;
  logic [7:0] wr_txd;

  task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    #1 wr_tx = tx_valid; wr_txd = tx_data;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a);
    @(negedge clk);
    host_addr = a; host_rd = 1'b1;
    #1 rd_val = host_rdata; rd_pop = rx_ready;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic wait_edges(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 irq", irq, 0);
    chk("R1 acc_err", acc_err, 0);
    bus_rd(1); chk("R1 ien", rd_val, 8'h00);
    bus_rd(2); chk("R1 iid", rd_val, 8'h00);
    bus_rd(3); chk("R1 lctl", rd_val, 8'h00);
    bus_rd(4); chk("R1 mctl", rd_val, 8'h00);
    bus_rd(5); chk("R8 lstat idle", rd_val, 8'h60);
  endtask

  task automatic t_rx_poll;
    @(negedge clk); rx_data = 8'hA5; rx_valid = 1'b1;
    bus_rd(5); chk("R8 lstat ready", rd_val, 8'h61);
    chk("R10 no irq when disabled", irq, 0);
    bus_rd(0); chk("R3 rx data", rd_val, 8'hA5); chk("R3 pop", rd_pop, 1);
    rx_valid = 1'b0;
    bus_rd(0); chk("R3 empty read", rd_val, 8'h00); chk("R3 no pop", rd_pop, 0);
  endtask

  task automatic t_rx_irq;
    bus_wr(1, 8'h01); chk("R6 rx enable no data", irq, 0);
    rx_data = 8'h3C; rx_valid = 1'b1;
    wait_edges(1); chk("R10 irq on arrival", irq, 1);
    bus_rd(2); chk("R7 iid pending", rd_val, 8'h01);
    bus_rd(0); chk("R3 pop data", rd_val, 8'h3C);
    chk("R3 irq cleared by pop", irq, 0);
    rx_data = 8'h5A;
    wait_edges(1); chk("R10 remaining byte re-raises", irq, 1);
    bus_wr(1, 8'h00); chk("R6 disable drops irq", irq, 0);
    bus_rd(2); chk("R6 cause dropped", rd_val, 8'h00);
    bus_rd(0); chk("R3 pop last", rd_val, 8'h5A);
    rx_valid = 1'b0;
    bus_rd(2); chk("R3 no cause after pop", rd_val, 8'h00);
  endtask

  task automatic t_tx;
    bus_wr(0, 8'h41); chk("R4 tx strobe", wr_tx, 1); chk("R4 tx byte", wr_txd, 8'h41);
    wait_edges(DLY + 5); chk("R5 no irq when disabled", irq, 0);
    bus_wr(1, 8'h02); chk("R6 tx enable raises irq", irq, 1);
    bus_rd(2); chk("R6 no cause yet", rd_val, 8'h00);
    bus_rd(1); chk("R6 ien readback", rd_val, 8'h02);
    // write edge is the posedge inside bus_wr; it returns half a cycle later
    bus_wr(0, 8'h42); chk("R4 irq cleared by send", irq, 0);
    wait_edges(DLY - 1); chk("R5 before delay", irq, 0);
    wait_edges(1); chk("R5 at delay", irq, 1);
    bus_rd(2); chk("R7 iid tx cause", rd_val, 8'h01);
    bus_wr(0, 8'h43);
    wait_edges(100);
    bus_wr(0, 8'h44);
    wait_edges(DLY - 1); chk("R5 restart before", irq, 0);
    wait_edges(1); chk("R5 restart at delay", irq, 1);
    bus_wr(0, 8'h45);
    wait_edges(50);
    bus_wr(1, 8'h00); chk("R6 disable", irq, 0);
    wait_edges(DLY); chk("R5 cancelled", irq, 0);
    bus_rd(2); chk("R5 no tx cause", rd_val, 8'h00);
  endtask

  task automatic t_div;
    bus_wr(3, 8'h80);
    bus_rd(3); chk("R7 lctl readback", rd_val, 8'h80);
    rx_data = 8'h99; rx_valid = 1'b1;
    bus_rd(0); chk("R2 read zero", rd_val, 8'h00); chk("R2 no pop", rd_pop, 0);
    bus_wr(0, 8'h11); chk("R2 no send", wr_tx, 0);
    bus_wr(1, 8'hFF);
    bus_rd(1); chk("R2 ien hidden", rd_val, 8'h00);
    rx_valid = 1'b0;
    bus_wr(3, 8'h03);
    bus_rd(1); chk("R2 ien unchanged", rd_val, 8'h00);
    bus_rd(3); chk("R7 lctl readback 2", rd_val, 8'h03);
  endtask

  task automatic t_mctl;
    bus_wr(4, 8'h05); bus_rd(4); chk("R9 plain write ignored", rd_val, 8'h00);
    bus_wr(4, 8'h1A); bus_rd(4); chk("R9 loopback pattern", rd_val, 8'h9A);
    bus_wr(7, 8'h77); bus_rd(7); chk("R9 scratch reads zero", rd_val, 8'h00);
    bus_wr(2, 8'hC7); bus_rd(2); chk("R9 fifo write ignored", rd_val, 8'h00);
    bus_rd(6); chk("R9 mstat zero", rd_val, 8'h00);
    chk("R9 no error", acc_err, 0);
  endtask

  task automatic t_err;
    bus_wr(5, 8'hFF); chk("R11 err set", acc_err, 1);
    bus_rd(5); chk("R11 lstat unchanged", rd_val, 8'h60);
    bus_wr(3, 8'h00); chk("R11 err sticky", acc_err, 1);
    bus_rd(4); chk("R11 mctl unchanged", rd_val, 8'h9A);
  endtask

  initial begin
    wr_tx = 1'b0; wr_txd = '0; rd_val = '0; rd_pop = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_rx_poll();
    t_rx_irq();
    t_tx();
    t_div();
    t_mctl();
    t_err();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule